// File: doc/BRIEF.md
# Stream-Cipher Masking Random Generator

This block supplies fresh pseudo-random bits to a masked block-cipher datapath. It holds a 177-bit nonlinear state built from two shift registers that feed each other. Each accepted update request returns a 160-bit word, which is enough randomness for 20 masked S-boxes: 16 on the data path and 4 on the key path.

After reset the state is loaded from the low 177 bits of a 288-bit seed constant. A reseed request starts a sequence of request/acknowledge transfers from an external entropy source, one 32-bit word per transfer. Each word overwrites one slice of the state. The slices are filled from the lowest bits upward: five full 32-bit slices, then a final 17-bit slice at the top of the state. While the reseed is running, update requests are ignored and the valid flag stays low.

Top module: `masking_prng`

## Requirements
- R1: After reset, `rnd_o` is 0, `rnd_valid_o` is 0, `busy_o` is 0 and `ent_req_o` is 0. The state equals bits [176:0] of the 288-bit `SEED` parameter.
- R2: The state bits are s[0]..s[176]. One keystream step produces the bit z = s[65]^s[92]^s[161]^s[176]. It then shifts s[91:0] up into s[92:1] and s[175:93] up into s[176:94]. The new s[0] is s[161]^s[176]^(s[174]&s[175])^s[68]. The new s[93] is s[65]^s[92]^(s[90]&s[91])^s[170].
- R3: An update is accepted when `next_i` is 1, `busy_o` is 0 and `reseed_i` is 0. On the next cycle, bit k of `rnd_o` is the z of step k (k = 0..159), the state has advanced 160 steps, and `rnd_valid_o` is 1.
- R4: When `reseed_i` is 1 and `busy_o` is 0, the next cycle has `busy_o` = 1, `ent_req_o` = 1 and `rnd_valid_o` = 0. `reseed_i` has priority over a `next_i` in the same cycle.
- R5: A transfer is a cycle with both `ent_req_o` and `ent_ack_i` high. Transfers fill the slices in ascending order. Slice p (p = 0..4) receives `ent_data_i` in state bits [32p+31:32p]. Slice 5 receives `ent_data_i[16:0]` in state bits [176:160]. `busy_o` falls on the cycle after the sixth transfer.
- R6: While `busy_o` is 1, `next_i` has no effect: `rnd_o` and the state do not change, and `rnd_valid_o` stays 0.
- R7: A `reseed_i` pulse while `busy_o` is 1 is ignored. The slice sequence does not restart.
- R8: `ent_ack_i` while `ent_req_o` is 0 has no effect on the state.
- R9: `rnd_o` changes only on the cycle after an accepted update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_i | input | 1 | Request a new 160-bit output word |
| reseed_i | input | 1 | Start a reseed sequence |
| ent_req_o | output | 1 | Entropy request |
| ent_ack_i | input | 1 | Entropy acknowledge |
| ent_data_i | input | 32 | Entropy word |
| busy_o | output | 1 | A reseed is in progress |
| rnd_o | output | 160 | Pseudo-random output word |
| rnd_valid_o | output | 1 | `rnd_o` holds a word produced since the last reseed started |

## Verification
The bench builds the block with the default parameters: a 177-bit state split 93/84, 32-bit entropy words, 160-bit outputs and the default 288-bit seed. These values make a reseed six transfers long, with a short 17-bit last slice. The bench therefore exercises the partial-slice mapping, and it compares every output word bit by bit against a serial model of the recurrence. Several entropy vectors, gaps between transfers, and update or reseed pulses during a reseed check the ordering and the ignore rules.

// File: rtl/masking_prng.sv
module masking_prng #(
  parameter int StateW = 177,
  parameter int RegAW  = 93,
  parameter int EntW   = 32,
  parameter int OutW   = 160,
  parameter int SeedW  = 288,
  parameter logic [SeedW-1:0] SEED =
    288'h9e3779b9_7f4a7c15_f39cc060_5cedc834_1082276b_f3a27251_f86c6a11_d0c18e95_2767f0b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            next_i,
  input  logic            reseed_i,
  output logic            ent_req_o,
  input  logic            ent_ack_i,
  input  logic [EntW-1:0] ent_data_i,
  output logic            busy_o,
  output logic [OutW-1:0] rnd_o,
  output logic            rnd_valid_o
);

  localparam int NumParts = (StateW + EntW - 1) / EntW;
  localparam int LastW    = StateW - (NumParts - 1) * EntW;
  localparam int PartW    = $clog2(NumParts);

  logic [StateW-1:0] st, st_adv, st_load;
  logic [OutW-1:0]   ks;
  logic [PartW-1:0]  part;
  logic              busy, take_next, xfer;

  function automatic logic [StateW-1:0] step(input logic [StateW-1:0] s);
    logic fb_a, fb_b;
    fb_a = s[161] ^ s[StateW-1] ^ (s[174] & s[175]) ^ s[68];
    fb_b = s[65] ^ s[RegAW-1] ^ (s[90] & s[91]) ^ s[170];
    return {s[StateW-2:RegAW], fb_b, s[RegAW-2:0], fb_a};
  endfunction

  always_comb begin
    logic [StateW-1:0] t;
    t = st;
    for (int k = 0; k < OutW; k++) begin
      ks[k] = t[65] ^ t[RegAW-1] ^ t[161] ^ t[StateW-1];
      t = step(t);
    end
    st_adv = t;
  end

  always_comb begin
    st_load = st;
    for (int p = 0; p < NumParts - 1; p++)
      if (part == PartW'(p)) st_load[p*EntW +: EntW] = ent_data_i;
    if (part == PartW'(NumParts - 1))
      st_load[StateW-1 -: LastW] = ent_data_i[LastW-1:0];
  end

  assign take_next   = next_i && !busy && !reseed_i;
  assign xfer        = busy && ent_ack_i;
  assign ent_req_o   = busy;
  assign busy_o      = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SEED[StateW-1:0];
      busy        <= 1'b0;
      part        <= '0;
      rnd_o       <= '0;
      rnd_valid_o <= 1'b0;
    end else if (busy) begin
      if (xfer) begin
        st <= st_load;
        if (part == PartW'(NumParts - 1)) begin
          busy <= 1'b0;
          part <= '0;
        end else begin
          part <= part + 1'b1;
        end
      end
    end else if (reseed_i) begin
      busy        <= 1'b1;
      part        <= '0;
      rnd_valid_o <= 1'b0;
    end else if (take_next) begin
      st          <= st_adv;
      rnd_o       <= ks;
      rnd_valid_o <= 1'b1;
    end
  end

  assert_valid_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rnd_valid_o);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reseed_i) |=> (busy_o && ent_req_o && !rnd_valid_o));

  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_next |=> $stable(rnd_o));

  assert_busy_ignores_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && next_i && !ent_ack_i) |=> $stable(st));

  assert_no_ack_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take_next) |=> $stable(st));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && part == PartW'(NumParts - 1)) |=> !busy_o);

  for (genvar p = 0; p < NumParts - 1; p++) begin : g_slice_chk
    assert_slice_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && part == PartW'(p)) |=> st[p*EntW +: EntW] == $past(ent_data_i));
  end

  assert_last_slice_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && part == PartW'(NumParts - 1)) |=>
      st[StateW-1 -: LastW] == $past(ent_data_i[LastW-1:0]));

endmodule

// File: tb/tb_masking_prng.sv
module tb_masking_prng;
  localparam logic [287:0] SEED =
    288'h9e3779b9_7f4a7c15_f39cc060_5cedc834_1082276b_f3a27251_f86c6a11_d0c18e95_2767f0b1;

  // each entry: six entropy words, word p in bits [32p+31:32p]
  localparam int NV = 4;
  localparam logic [191:0] VEC [NV] = '{
    192'h00000000_00000000_00000000_00000000_00000000_00000000,
    192'hffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff,
    192'h0001a5a5_c3c3c3c3_12345678_9abcdef0_0f1e2d3c_4b5a6978,
    192'hdeadbeef_00ff00ff_a5a55a5a_13579bdf_2468ace0_80000001
  };

  logic clk = 0, rst_n = 0;
  logic next_i = 0, reseed_i = 0, ent_ack_i = 0;
  logic [31:0] ent_data_i = '0;
  logic ent_req_o, busy_o, rnd_valid_o;
  logic [159:0] rnd_o;

  int total = 0, fails = 0;
  logic [176:0] m;
  logic [159:0] exp_out;

  always #5 clk = ~clk;

  masking_prng dut (.clk(clk), .rst_n(rst_n), .next_i(next_i), .reseed_i(reseed_i),
    .ent_req_o(ent_req_o), .ent_ack_i(ent_ack_i), .ent_data_i(ent_data_i),
    .busy_o(busy_o), .rnd_o(rnd_o), .rnd_valid_o(rnd_valid_o));

  task automatic chk(input string r, input logic [159:0] act, input logic [159:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, expv);
    end
  endtask

  // bit-serial reference of the recurrence (R2)
  task automatic model_update();
    logic z, a, b;
    for (int k = 0; k < 160; k++) begin
      z = m[65] ^ m[92] ^ m[161] ^ m[176];
      a = m[161] ^ m[176] ^ (m[174] & m[175]) ^ m[68];
      b = m[65] ^ m[92] ^ (m[90] & m[91]) ^ m[170];
      exp_out[k] = z;
      for (int i = 176; i > 93; i--) m[i] = m[i-1];
      m[93] = b;
      for (int i = 92; i > 0; i--) m[i] = m[i-1];
      m[0] = a;
    end
  endtask

  task automatic do_next(input string r);
    @(negedge clk); next_i = 1;
    @(negedge clk); next_i = 0;
    model_update();
    chk(r, rnd_o, exp_out);
    chk(r, {159'd0, rnd_valid_o}, 160'd1);
  endtask

  task automatic xfer(input int p, input logic [31:0] w);
    @(negedge clk); ent_ack_i = 1; ent_data_i = w;
    @(negedge clk); ent_ack_i = 0;
    if (p < 5) m[p*32 +: 32] = w; else m[176:160] = w[16:0];
  endtask

  task automatic start_reseed();
    @(negedge clk); reseed_i = 1;
    @(negedge clk); reseed_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [159:0] held;
    m = SEED[176:0];
    repeat (3) @(negedge clk);
    chk("R1 rnd", rnd_o, '0);
    chk("R1 flags", {157'd0, rnd_valid_o, busy_o, ent_req_o}, '0);
    rst_n = 1;
    @(negedge clk);
    do_next("R1 R2 R3 first word from seed");
    do_next("R3 second word");

    for (int v = 0; v < NV; v++) begin
      start_reseed();
      chk("R4 busy/req/valid", {157'd0, busy_o, ent_req_o, rnd_valid_o}, 160'b110);
      for (int p = 0; p < 6; p++) begin
        xfer(p, VEC[v][p*32 +: 32]);
        if (v == 1 && p == 2) repeat (3) @(negedge clk);
      end
      chk("R5 busy falls", {159'd0, busy_o}, '0);
      for (int u = 0; u < 3; u++) do_next("R2 R3 R5 after reseed");
    end

    // next during reseed is ignored
    held = rnd_o;
    start_reseed();
    @(negedge clk); next_i = 1;
    @(negedge clk); next_i = 0;
    chk("R6 rnd held", rnd_o, held);
    chk("R6 valid low", {159'd0, rnd_valid_o}, '0);
    xfer(0, 32'hcafef00d);
    xfer(1, 32'h0badc0de);
    // reseed while busy is ignored
    @(negedge clk); reseed_i = 1;
    @(negedge clk); reseed_i = 0;
    xfer(2, 32'h11111111);
    xfer(3, 32'h22222222);
    xfer(4, 32'h33333333);
    chk("R7 still busy", {159'd0, busy_o}, 160'd1);
    xfer(5, 32'hfffe4444);
    chk("R7 done after six", {159'd0, busy_o}, '0);
    do_next("R6 R7 state after ignored pulses");

    // ack without request
    @(negedge clk); ent_ack_i = 1; ent_data_i = 32'h5555aaaa;
    @(negedge clk); ent_ack_i = 0;
    chk("R8 busy", {159'd0, busy_o}, '0);
    do_next("R8 state unaffected");

    // reseed priority over next
    held = rnd_o;
    @(negedge clk); reseed_i = 1; next_i = 1;
    @(negedge clk); reseed_i = 0; next_i = 0;
    chk("R4 priority rnd held", rnd_o, held);
    chk("R4 priority busy", {159'd0, busy_o}, 160'd1);
    for (int p = 0; p < 6; p++) xfer(p, 32'h01010101 * (p + 1));

    // output holds without update
    held = rnd_o;
    repeat (4) @(negedge clk);
    chk("R9 hold", rnd_o, held);
    do_next("R3 R9 after priority reseed");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule